// File: doc/BRIEF.md
# Single-Cycle Bus SRAM with Low-Address Alias

This block is an 8 KB data memory that sits on a synchronous system bus as a slave. A master presents an address, a direction flag, a transfer size, write data and a select strobe, and the memory completes the access on the next rising clock edge. Reads return a full 32-bit word. Writes change only the byte lanes picked by the size code and the low address bits. No access ever stalls.

The memory always answers in a fixed window high in the address map. A remap input, driven by an external system controller, adds a second window at address zero. Both windows reach the same storage, so boot code or vectors can be placed at zero and still be seen at the high address. A selected access is flagged as an error, and changes nothing, in three cases: it falls outside every active window, it is misaligned for its size, or it uses the reserved size code.

Top module: `busSramRemap`

## Requirements
- R1: The storage holds 2048 words of 32 bits. The word index is address bits [12:2], so the word at index 0 and the word at index 2047 can both be written and read back.
- R2: A selected access with address in 0x10000000..0x10001FFF always reaches the storage, whatever the remap input is.
- R3: While the remap input is high, addresses 0x00000000..0x00001FFF reach the same words as the high window at the same offset. While it is low, such an access is an error and writes nothing.
- R4: Size code 00 writes one byte, 01 writes a half-word and 10 writes a word. Lanes are little-endian: the byte at address offset k travels on write-data bits [8k+7:8k]. Only the addressed lanes of the word change.
- R5: A valid read sets the ack output and puts the addressed 32-bit word on the read-data output after the same clock edge that samples the request.
- R6: Every valid access is acknowledged after exactly one clock edge. The wait output is never high, and ack and error are never high together.
- R7: While select is low, nothing is written, and after the next edge ack, error and read data are all zero.
- R8: A half-word access with address bit 0 set, a word access with address bits [1:0] nonzero, or any access with size code 11 raises the error output after the next edge and writes nothing.
- R9: A selected access whose address lies outside every active window raises the error output after the next edge and writes nothing.
- R10: While reset is low, ack, error and read data are zero. Reset does not alter the stored contents.
- R11: Read data is zero after every edge that did not complete a valid read, including writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Slave select; the memory takes part only while high |
| wrEn | input | 1 | Direction: 1 = write, 0 = read |
| size | input | 2 | Transfer size: 00 byte, 01 half-word, 10 word, 11 reserved |
| addr | input | 32 | Byte address |
| wrData | input | 32 | Write data, little-endian lanes |
| remapEn | input | 1 | Adds the alias window at address zero while high |
| rdData | output | 32 | Read data of the last valid read, otherwise zero |
| ack | output | 1 | Last sampled access completed without error |
| err | output | 1 | Last sampled access was refused |
| waitResp | output | 1 | Wait response; always low |

## Verification
Every response is due after exactly one rising edge. The edge that samples a request also updates ack, error and read data, and a write becomes visible to a read presented on the following cycle. The bench drives each request just after a falling edge, waits for one rising edge, and then compares all four outputs at the next falling edge against a byte-array model. Only after that comparison does it apply the write to the model. Reset is checked while it is held low, and the stored contents are read back once it is released.

// File: rtl/sramPkg.sv
package sramPkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xferSize_e;

  // Strobes from the control module to the datapath for one access.
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    logic [LANES-1:0] laneEn;
  } memStrobes_t;

endpackage

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
#(
  parameter int                 TAG_W   = 19,
  parameter logic [TAG_W-1:0]   HI_TAG  = 19'h08000,
  parameter logic [TAG_W-1:0]   LO_TAG  = 19'h00000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             wrEn,
  input  logic             remapEn,
  input  logic [1:0]       size,
  input  logic [TAG_W-1:0] winTag,
  input  logic [1:0]       lowBits,
  output memStrobes_t      strb,
  output logic             ackQ,
  output logic             errQ
);

  xferSize_e        sizeCode;
  logic             hiHit;
  logic             loHit;
  logic             aligned;
  logic             accessOk;
  logic [LANES-1:0] laneSel;

  assign sizeCode = xferSize_e'(size);

  // Window decode: high window always, low alias only while remapped.
  assign hiHit = (winTag == HI_TAG);
  assign loHit = remapEn && (winTag == LO_TAG);

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = (lowBits[0] == 1'b0);
      SZ_WORD: aligned = (lowBits == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  // Per-lane enable, little-endian lane numbering.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] LID = l[1:0];
    always_comb begin
      unique case (sizeCode)
        SZ_BYTE: laneSel[l] = (lowBits == LID);
        SZ_HALF: laneSel[l] = (lowBits[1] == LID[1]);
        SZ_WORD: laneSel[l] = 1'b1;
        default: laneSel[l] = 1'b0;
      endcase
    end
  end

  assign accessOk = sel && (hiHit || loHit) && aligned;

  always_comb begin
    strb.wrStb  = accessOk && wrEn;
    strb.rdStb  = accessOk && !wrEn;
    strb.laneEn = accessOk ? laneSel : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      ackQ <= accessOk;
      errQ <= sel && !accessOk;
    end
  end

  // R7: an idle cycle produces no response.
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> (!ackQ && !errQ));

  // R8: the reserved size code is always refused.
  a_r8_rsvd_size_err: assert property (@(posedge clk) disable iff (!rstN)
    (sel && size == 2'b11) |=> errQ);

  // R8: a misaligned word access is refused.
  a_r8_word_misalign_err: assert property (@(posedge clk) disable iff (!rstN)
    (sel && size == 2'b10 && lowBits != 2'b00) |=> errQ);

  // R3: the alias window is closed while remap is low.
  a_r3_alias_closed: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !remapEn && winTag == LO_TAG) |=> (errQ && !ackQ));

  // R2: an aligned word access in the high window is acknowledged.
  a_r2_high_ack: assert property (@(posedge clk) disable iff (!rstN)
    (sel && winTag == HI_TAG && size == 2'b10 && lowBits == 2'b00) |=> ackQ);

endmodule

// File: rtl/sramData.sv
module sramData
  import sramPkg::*;
#(
  parameter int WORDS = 2048,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  memStrobes_t               strb,
  input  logic [IDX_W-1:0]          wordIdx,
  input  logic [LANES*LANE_W-1:0]   wrData,
  output logic [LANES*LANE_W-1:0]   rdData
);

  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Storage has no reset: contents survive a reset.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (strb.wrStb && strb.laneEn[l]) begin
        mem[wordIdx][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= strb.rdStb ? mem[wordIdx] : '0;
    end
  end

  // R4: a write always enables at least one lane.
  a_r4_write_has_lane: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |-> (strb.laneEn != '0));

  // R6: read and write strobes never coincide.
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrStb && strb.rdStb));

endmodule

// File: rtl/busSramRemap.sv
module busSramRemap
  import sramPkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 13,
  parameter logic [31:0] HI_BASE  = 32'h1000_0000,
  parameter logic [31:0] LO_BASE  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        wrEn,
  input  logic [1:0]  size,
  input  logic [31:0] addr,
  input  logic [31:0] wrData,
  input  logic        remapEn,
  output logic [31:0] rdData,
  output logic        ack,
  output logic        err,
  output logic        waitResp
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam int WORDS = (1 << WIN_BITS) / LANES;
  localparam int IDX_W = WIN_BITS - 2;
  localparam logic [TAG_W-1:0] HI_TAG = HI_BASE[ADDR_W-1:WIN_BITS];
  localparam logic [TAG_W-1:0] LO_TAG = LO_BASE[ADDR_W-1:WIN_BITS];

  memStrobes_t strb;

  sramCtrl #(
    .TAG_W  (TAG_W),
    .HI_TAG (HI_TAG),
    .LO_TAG (LO_TAG)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (sel),
    .wrEn    (wrEn),
    .remapEn (remapEn),
    .size    (size),
    .winTag  (addr[ADDR_W-1:WIN_BITS]),
    .lowBits (addr[1:0]),
    .strb    (strb),
    .ackQ    (ack),
    .errQ    (err)
  );

  sramData #(
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordIdx (addr[WIN_BITS-1:2]),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  // Every access finishes in one cycle.
  assign waitResp = 1'b0;

  // R6: ack and error are exclusive.
  a_r6_ack_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && err));

  // R11: read data is zero unless a read was acknowledged.
  a_r11_rdata_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> (rdData == '0));

  // R10: outputs are zero while reset is held.
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!ack && !err && rdData == '0));

endmodule

// File: tb/busSramRemap_test.sv
`timescale 1ns/1ps
module busSramRemap_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        remapEn = 1'b0;
  logic [31:0] rdData;
  logic        ack, err, waitResp;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] model [8192];

  always #2.5 clk = ~clk;

  busSramRemap uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .size(size),
    .addr(addr), .wrData(wrData), .remapEn(remapEn),
    .rdData(rdData), .ack(ack), .err(err), .waitResp(waitResp)
  );

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    report();
  end

  task automatic checkOut(input string tag, input logic eAck, input logic eErr,
                          input logic [31:0] eRd);
    testsRun++;
    if (ack !== eAck || err !== eErr || rdData !== eRd || waitResp !== 1'b0) begin
      testsFailed++;
      $display("FAIL %s: actual ack=%b err=%b wait=%b rd=%h expected ack=%b err=%b wait=0 rd=%h",
               tag, ack, err, waitResp, rdData, eAck, eErr, eRd);
    end
  endtask

  // One bus transfer; inputs set after a falling edge, outputs due after
  // the next rising edge and sampled at the falling edge that follows.
  task automatic xfer(input logic s, input logic w, input logic [31:0] a,
                      input logic [1:0] sz, input logic [31:0] d, input string hint);
    logic hit, alg, good, eAck, eErr;
    logic [31:0] eRd;
    logic [12:0] base;
    logic [3:0] lanes;
    string tag;
    sel = s; wrEn = w; addr = a; size = sz; wrData = d;
    hit  = (a[31:13] == 19'h08000) || (remapEn && a[31:13] == 19'h0);
    case (sz)
      2'b00: alg = 1'b1;
      2'b01: alg = (a[0] == 1'b0);
      2'b10: alg = (a[1:0] == 2'b00);
      default: alg = 1'b0;
    endcase
    good = s && hit && alg;
    eAck = good;
    eErr = s && !good;
    base = {a[12:2], 2'b00};
    eRd = (good && !w) ? {model[base+3], model[base+2], model[base+1], model[base]} : 32'h0;
    case (sz)
      2'b00: lanes = 4'b0001 << a[1:0];
      2'b01: lanes = a[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
    if (hint != "") tag = hint;
    else if (!s) tag = "R7";
    else if (!alg) tag = "R8";
    else if (!hit) tag = "R9";
    else if (!w) tag = "R5";
    else tag = "R11";
    @(posedge clk);
    @(negedge clk);
    checkOut(tag, eAck, eErr, eRd);
    if (good && w)
      for (int l = 0; l < 4; l++)
        if (lanes[l]) model[base + 13'(l)] = d[8*l +: 8];
    sel = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input string hint);
    xfer(1'b1, 1'b0, a, 2'b10, 32'h0, hint);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    checkOut("R10", 1'b0, 1'b0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Fill every word through the high window.
    for (int w = 0; w < 2048; w++)
      xfer(1'b1, 1'b1, 32'h1000_0000 + 32'(w*4), 2'b10, 32'(w) * 32'h9E37_79B9 ^ 32'hA5A5_0000, "R2");
    rd(32'h1000_0000, "R1");
    rd(32'h1000_1FFC, "R1");
    rd(32'h1000_0800, "R2");

    // Sub-word writes.
    xfer(1'b1, 1'b1, 32'h1000_0011, 2'b00, 32'h0000_BB00, "R4");
    xfer(1'b1, 1'b1, 32'h1000_0013, 2'b00, 32'hCC00_0000, "R4");
    rd(32'h1000_0010, "R4");
    xfer(1'b1, 1'b1, 32'h1000_0022, 2'b01, 32'h1234_0000, "R4");
    xfer(1'b1, 1'b1, 32'h1000_0024, 2'b01, 32'h0000_5678, "R4");
    rd(32'h1000_0020, "R4");
    rd(32'h1000_0024, "R4");

    // Alias window closed, then opened.
    xfer(1'b1, 1'b1, 32'h0000_0040, 2'b10, 32'hDEAD_BEEF, "R3");
    rd(32'h0000_0040, "R3");
    rd(32'h1000_0040, "R3");
    @(negedge clk); remapEn = 1'b1;
    xfer(1'b1, 1'b1, 32'h0000_0040, 2'b10, 32'hDEAD_BEEF, "R3");
    rd(32'h1000_0040, "R3");
    xfer(1'b1, 1'b1, 32'h1000_1FFE, 2'b01, 32'h7777_0000, "R3");
    rd(32'h0000_1FFC, "R3");
    rd(32'h1000_0044, "R2");
    remapEn = 1'b0;
    rd(32'h1000_0040, "R2");

    // Refused accesses leave storage unchanged.
    xfer(1'b1, 1'b1, 32'h1000_0051, 2'b01, 32'hFFFF_FFFF, "R8");
    xfer(1'b1, 1'b1, 32'h1000_0052, 2'b10, 32'hFFFF_FFFF, "R8");
    xfer(1'b1, 1'b1, 32'h1000_0050, 2'b11, 32'hFFFF_FFFF, "R8");
    rd(32'h1000_0050, "R8");
    xfer(1'b1, 1'b1, 32'h1000_2000, 2'b10, 32'hFFFF_FFFF, "R9");
    xfer(1'b1, 1'b1, 32'h2000_0050, 2'b10, 32'hFFFF_FFFF, "R9");
    rd(32'h1000_0000, "R9");
    rd(32'h1000_0050, "R9");
    xfer(1'b0, 1'b1, 32'h1000_0060, 2'b10, 32'hFFFF_FFFF, "R7");
    rd(32'h1000_0060, "R7");
    xfer(1'b0, 1'b0, 32'h1000_0060, 2'b10, 32'h0, "R7");

    // Mixed traffic.
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [1:0] sz;
      int r;
      r = int'($urandom % 8);
      if (r < 5) a = 32'h1000_0000 | 32'($urandom % 8192);
      else if (r < 7) a = 32'($urandom % 8192);
      else a = $urandom;
      sz = 2'($urandom % 4);
      if (($urandom % 5) != 0) begin
        if (sz == 2'b11) sz = 2'b10;
        if (sz == 2'b10) a[1:0] = 2'b00;
        if (sz == 2'b01) a[0] = 1'b0;
      end
      if (($urandom % 50) == 0) remapEn = ~remapEn;
      xfer(($urandom % 8) != 0, ($urandom % 2) != 0, a, sz, $urandom, "");
    end

    // Reset keeps contents.
    remapEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R10", 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(32'h1000_0010, "R10");
    rd(32'h1000_1FFC, "R10");
    rd(32'h1000_0800, "R10");

    report();
  end

endmodule